// File: doc/BRIEF.md
# Patterned Dot-Clock Enable Generator

This block derives a pixel (dot) clock enable for each of two display channels, a main and a secondary one. A source strobe is picked from three incoming tick streams: bus, peripheral or external. Each channel then either passes the chosen strobe straight through, or divides it by walking a programmable bit pattern. A pattern pointer steps once per source tick over a window of m positions. A dot-clock pulse is issued only on ticks where the pattern bit under the pointer is one. Software normally loads the low m/2 pattern bits with ones, which gives an output close to 50% duty.

The block has four write-only registers and one readable status. A control word holds the source select and one divider field per channel. Each channel has its own pattern word. A stop word halts or restarts both channels. Stopping takes effect at once. Restarting is a handshake: the stop status stays set until the first selected source tick after release, and only then does pulse generation resume from pattern position 0. A new divider value is held back until the running pattern window wraps, so a ratio change never cuts a window short.

Top module: `dot_clock_gen`

## Requirements
- R1: After reset both dot-clock enables are 0 and the stop status is 0.
- R2: Control bits 17:16 select the source tick: 0 bus (src_tick[0]), 1 peripheral (src_tick[1]), 2 external (src_tick[2]). Ticks on unselected sources produce no pulse. Value 3 selects nothing, and no pulse is ever produced with it.
- R3: A divider field with bit 6 set is a bypass. dot_en of that channel is high in the cycle after each selected tick, and low otherwise.
- R4: The main channel divider sits in control bits 6:0 and the secondary one in bits 14:8. With bit 6 clear, the ratio m is bits 5:0. The pointer starts at 0, advances on each selected tick, and wraps to 0 after position m-1. A tick seen at pointer p pulses dot_en in the next cycle exactly when bit p of that channel's pattern word is 1. The main pattern is at address 1 and the secondary at address 2. The control word is at address 0 and the stop word at address 3.
- R5: A divider field of 0 (bit 6 clear, ratio 0) keeps the channel's dot_en at 0.
- R6: A ratio above PAT_W (32 by default) acts as PAT_W.
- R7: A divider write made while a channel is dividing takes effect only when that channel's pointer wraps.
- R8: Writing 1 in bit 0 of the stop word sets the stop status at the next edge. While the status is set, both enables are 0 and the pointers are held at 0.
- R9: Writing 0 in bit 0 of the stop word does not clear the status at once. The status clears at the first selected source tick after the release. That tick produces no pulse, and counting restarts at pointer 0.
- R10: No dot_en pulse appears in a cycle that does not follow a source tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 3 | Source tick strobes: bus, peripheral, external |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 main pattern, 2 secondary pattern, 3 stop |
| wr_data | input | 32 | Register write data |
| dot_en | output | 2 | Dot-clock enable per channel, bit 0 main, bit 1 secondary |
| stopped | output | 1 | Stop status, 1 while halted or awaiting restart |

## Verification
A register write takes effect at the clock edge that samples it. The stop status changes at that same edge for a stop, and at the edge of the first selected tick after a release. A dot_en pulse is registered, so it is visible in the cycle after its tick. Every input is driven on a falling edge and held for one full cycle. Outputs are read on the following falling edge, or counted there by a monitor and read a small delay after a falling edge. Each read therefore sees exactly one registered update. Pulse counts over whole tick trains are compared against counts worked out from the pattern, the ratio and the starting pointer of 0.

// File: rtl/dck_pkg.sv
package dck_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_CH     = 2;
    localparam int NUM_SRC    = 3;
    localparam int DIV_W      = 7;
    localparam int BYPASS_BIT = 6;
    localparam int SEL_LSB    = 16;
    localparam int SEL_W      = 2;
    localparam int DIV_LSB_MAIN = 0;
    localparam int DIV_LSB_SUB  = 8;

    typedef enum logic [1:0] {
        ADDR_CTRL     = 2'd0,
        ADDR_PAT_MAIN = 2'd1,
        ADDR_PAT_SUB  = 2'd2,
        ADDR_STOP     = 2'd3
    } reg_addr_e;

    function automatic int div_lsb(input int ch);
        return (ch == 0) ? DIV_LSB_MAIN : DIV_LSB_SUB;
    endfunction
endpackage

// File: rtl/dck_regs.sv
module dck_regs
    import dck_pkg::*;
#(
    parameter int PAT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          sel_tick,
    output logic [SEL_W-1:0]              src_sel,
    output logic [NUM_CH-1:0][DIV_W-1:0]  div_field,
    output logic [NUM_CH-1:0][PAT_W-1:0]  pattern,
    output logic                          stop_req,
    output logic                          stopped
);
    typedef struct packed {
        logic [SEL_W-1:0]             sel;
        logic [NUM_CH-1:0][DIV_W-1:0] div;
        logic [NUM_CH-1:0][PAT_W-1:0] pat;
        logic                         stop_req;
        logic                         stopped;
    } regs_t;

    regs_t st_d, st_q;
    reg_addr_e addr;
    logic stop_set;

    assign addr     = reg_addr_e'(wr_addr);
    assign stop_set = wr_en && (addr == ADDR_STOP) && wr_data[0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                ADDR_CTRL: begin
                    st_d.sel = wr_data[SEL_LSB +: SEL_W];
                    for (int c = 0; c < NUM_CH; c++) begin
                        st_d.div[c] = wr_data[div_lsb(c) +: DIV_W];
                    end
                end
                ADDR_PAT_MAIN: st_d.pat[0]   = wr_data[PAT_W-1:0];
                ADDR_PAT_SUB:  st_d.pat[1]   = wr_data[PAT_W-1:0];
                default:       st_d.stop_req = wr_data[0];
            endcase
        end
        if (stop_set) begin
            st_d.stopped = 1'b1;
        end else if (st_q.stopped && !st_q.stop_req && sel_tick) begin
            st_d.stopped = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    assign src_sel   = st_q.sel;
    assign div_field = st_q.div;
    assign pattern   = st_q.pat;
    assign stop_req  = st_q.stop_req;
    assign stopped   = st_q.stopped;
endmodule

// File: rtl/dck_src_sel.sv
module dck_src_sel
    import dck_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   src_sel,
    output logic               sel_tick
);
    always_comb begin
        case (src_sel)
            2'd0:    sel_tick = src_tick[0];
            2'd1:    sel_tick = src_tick[1];
            2'd2:    sel_tick = src_tick[2];
            default: sel_tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/dck_chan.sv
module dck_chan
    import dck_pkg::*;
#(
    parameter int PAT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_field,
    input  logic [PAT_W-1:0] pattern,
    output logic             dot_en
);
    localparam int PTR_W   = $clog2(PAT_W);
    localparam int RATIO_W = $clog2(PAT_W + 1);

    typedef struct packed {
        logic [DIV_W-1:0] act;
        logic [PTR_W-1:0] ptr;
        logic             out;
    } chan_t;

    chan_t cs_d, cs_q;
    logic [RATIO_W-1:0] ratio;
    logic               bypass;
    logic               at_wrap;

    function automatic logic [RATIO_W-1:0] eff_ratio(input logic [DIV_W-1:0] f);
        logic [5:0] raw;
        raw = f[5:0];
        if (int'(raw) > PAT_W) begin
            return RATIO_W'(PAT_W);
        end
        return RATIO_W'(raw);
    endfunction

    assign bypass  = cs_q.act[BYPASS_BIT];
    assign ratio   = eff_ratio(cs_q.act);
    assign at_wrap = (RATIO_W'(cs_q.ptr) == (ratio - RATIO_W'(1)));

    always_comb begin
        cs_d     = cs_q;
        cs_d.out = 1'b0;
        if (!run) begin
            cs_d.act = div_field;
            cs_d.ptr = '0;
        end else if (bypass) begin
            cs_d.out = tick;
            cs_d.act = div_field;
            cs_d.ptr = '0;
        end else if (ratio == '0) begin
            cs_d.act = div_field;
            cs_d.ptr = '0;
        end else begin
            cs_d.out = tick & pattern[cs_q.ptr];
            if (tick) begin
                if (at_wrap) begin
                    cs_d.ptr = '0;
                    cs_d.act = div_field;
                end else begin
                    cs_d.ptr = cs_q.ptr + PTR_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign dot_en = cs_q.out;
endmodule

// File: rtl/dot_clock_gen.sv
module dot_clock_gen
    import dck_pkg::*;
#(
    parameter int PAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        src_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic [1:0]        dot_en,
    output logic              stopped
);
    logic [SEL_W-1:0]             src_sel;
    logic [NUM_CH-1:0][DIV_W-1:0] div_field;
    logic [NUM_CH-1:0][PAT_W-1:0] pattern;
    logic                         stop_req;
    logic                         sel_tick;
    logic                         halted;

    dck_regs #(.PAT_W(PAT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sel_tick  (sel_tick),
        .src_sel   (src_sel),
        .div_field (div_field),
        .pattern   (pattern),
        .stop_req  (stop_req),
        .stopped   (halted)
    );

    dck_src_sel u_src (
        .src_tick (src_tick),
        .src_sel  (src_sel),
        .sel_tick (sel_tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dck_chan #(.PAT_W(PAT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (!halted),
            .tick      (sel_tick),
            .div_field (div_field[c]),
            .pattern   (pattern[c]),
            .dot_en    (dot_en[c])
        );
    end

    assign stopped = halted;
endmodule

// File: rtl/dck_checker.sv
module dck_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] src_tick,
    input logic       stop_wr1,
    input logic [1:0] dot_en,
    input logic       stopped,
    input logic [1:0] src_sel,
    input logic       stop_req
);
    a_r8_stop_sets: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr1 |=> stopped);

    a_r8_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> (dot_en == 2'b00));

    a_r9_release_before_run: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stopped) |-> !$past(stop_req));

    a_r8_stop_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped) |-> $past(stop_wr1));

    a_r10_no_tick_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (src_tick == 3'b000) |=> (dot_en == 2'b00));

    a_r2_invalid_select: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd3) |=> (dot_en == 2'b00));
endmodule

bind dot_clock_gen dck_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .stop_wr1 (wr_en && (wr_addr == 2'd3) && wr_data[0]),
    .dot_en   (dot_en),
    .stopped  (stopped),
    .src_sel  (src_sel),
    .stop_req (stop_req)
);

// File: tb/dot_clock_gen_test.sv
module dot_clock_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_tick = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  dot_en;
    logic        stopped;

    int checks = 0;
    int fails  = 0;
    int cnt0   = 0;
    int cnt1   = 0;
    int base0, base1;

    dot_clock_gen uut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dot_en(dot_en), .stopped(stopped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cnt0 <= cnt0 + int'(dot_en[0]);
        cnt1 <= cnt1 + int'(dot_en[1]);
    end

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] pat0;
        logic [31:0] pat1;
        logic [1:0]  tsrc;
        logic [7:0]  nticks;
        logic [7:0]  exp0;
        logic [7:0]  exp1;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'h0000_0204, 32'h3, 32'h1, 2'd0, 8'd8,  8'd4, 8'd4},   // R4 main 4, sub 2
        '{32'h0001_0040, 32'h0, 32'h0, 2'd1, 8'd5,  8'd5, 8'd0},   // R3 bypass, R5 off
        '{32'h0002_0603, 32'h5, 32'h7, 2'd2, 8'd12, 8'd8, 8'd6},   // R4 ratios 3 and 6
        '{32'h0000_0128, 32'h8000_0000, 32'h1, 2'd0, 8'd64, 8'd2, 8'd64}, // R6 clamp
        '{32'h0002_4040, 32'h0, 32'h0, 2'd0, 8'd6,  8'd0, 8'd0}    // R2 unselected source
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        src_tick[s] = 1'b1;
        @(negedge clk);
        src_tick = '0;
    endtask

    task automatic mark();
        @(negedge clk); #1;
        base0 = cnt0; base1 = cnt1;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic setup(input logic [31:0] c, input logic [31:0] p0, input logic [31:0] p1);
        wr(2'd3, 32'd1);
        wr(2'd0, c);
        wr(2'd1, p0);
        wr(2'd2, p1);
        wr(2'd3, 32'd0);
        check(stopped == 1'b1, "R9 status held after release", int'(stopped), 1);
        pulse(int'(c[17:16]));
        check(stopped == 1'b0, "R9 status cleared by first tick", int'(stopped), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dot_en == 2'b00, "R1 reset enables", int'(dot_en), 0);
        check(stopped == 1'b0, "R1 reset status", int'(stopped), 0);

        wr(2'd3, 32'd1);
        check(stopped == 1'b1, "R8 stop sets status", int'(stopped), 1);

        for (int i = 0; i < 5; i++) begin
            setup(VECS[i].ctrl, VECS[i].pat0, VECS[i].pat1);
            mark();
            for (int k = 0; k < int'(VECS[i].nticks); k++) pulse(int'(VECS[i].tsrc));
            settle();
            check(cnt0 - base0 == int'(VECS[i].exp0), $sformatf("R4 vector %0d main", i),
                  cnt0 - base0, int'(VECS[i].exp0));
            check(cnt1 - base1 == int'(VECS[i].exp1), $sformatf("R4 vector %0d sub", i),
                  cnt1 - base1, int'(VECS[i].exp1));
        end

        // R8: halted channels stay quiet
        setup(32'h0000_4040, 32'h0, 32'h0);
        wr(2'd3, 32'd1);
        mark();
        for (int k = 0; k < 3; k++) pulse(0);
        settle();
        check(cnt0 - base0 + cnt1 - base1 == 0, "R8 no pulses while stopped",
              cnt0 - base0 + cnt1 - base1, 0);
        check(stopped == 1'b1, "R8 status stays set", int'(stopped), 1);

        // R2: select value 3 gives nothing
        setup(32'h0000_4040, 32'h0, 32'h0);
        wr(2'd0, 32'h0003_4040);
        mark();
        for (int s = 0; s < 3; s++) begin
            pulse(s);
            pulse(s);
        end
        settle();
        check(cnt0 - base0 + cnt1 - base1 == 0, "R2 select 3 silent",
              cnt0 - base0 + cnt1 - base1, 0);

        // R7: ratio change waits for wrap
        setup(32'h0000_0004, 32'h9, 32'h0);
        pulse(0); pulse(0);
        wr(2'd0, 32'h0000_0002);
        mark();
        pulse(0); pulse(0);
        settle();
        check(cnt0 - base0 == 1, "R7 old ratio finishes window", cnt0 - base0, 1);
        mark();
        for (int k = 0; k < 6; k++) pulse(0);
        settle();
        check(cnt0 - base0 == 3, "R7 new ratio after wrap", cnt0 - base0, 3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule